// File: doc/BRIEF.md
# TDM Cascade Slot Serializer

This block drives the serial data line of a 256-bit time-division multiplexed audio frame. The frame is divided into eight slots of 32 bit clocks. The block puts its own left and right 24-bit samples into the first two slots, MSB first, with the unused tail of each slot held low. Whatever arrives on the cascade input comes back out 64 bit clocks later. Up to four such blocks can therefore be chained so that the last one carries eight channels.

The block runs entirely on the bit clock. In lead (master) mode it generates the frame clock itself: a pulse one slot long that is active high for left-justified framing and active low for I2S-style framing. In follow (slave) mode it locks its slot position to the start edge of an incoming frame clock. A pulse of any width, down to one bit clock, is accepted. In I2S-style framing the whole slot grid begins one bit clock after the frame-clock edge.

The cascade input is sampled on the falling edge of the bit clock. Output data changes on the rising edge.

Top module: `tdm_chain_serializer`

## Requirements
- R1: The frame position runs 0 to 255 and advances by one on each rising bit-clock edge, wrapping from 255 to 0. In lead mode it is free-running.
- R2: Left sample bit 23 down to bit 0 appear on `sdo` at positions 0 to 23, and right sample bit 23 down to bit 0 at positions 32 to 55.
- R3: `sdo` is low at positions 24 to 31 and 56 to 63, whatever the sample values.
- R4: A `tdm_in` value presented in bit period n appears on `sdo` in bit period n+64. It occupies positions 64 to 255.
- R5: In lead mode with left-justified framing (`i2s_align`=0), `fclk_out` is high at positions 0 to 31 and low elsewhere.
- R6: In lead mode with I2S framing (`i2s_align`=1), `fclk_out` is low at position 255 and at positions 0 to 30, and high elsewhere.
- R7: In follow mode with left-justified framing, suppose the `fclk_in` value sampled at a rising edge is 1 and the value sampled at the edge before was 0. Then the bit period starting at that edge is position 0.
- R8: In follow mode with I2S framing, suppose the `fclk_in` value sampled at a rising edge is 0 and the previous sample was 1. Then that bit period is position 255, and the next period is position 0.
- R9: In follow mode a frame-clock pulse one bit clock wide, or one arriving mid-frame, restarts the frame exactly as a wide pulse does.
- R10: Both sample words are captured at the rising edge that begins position 0. A change of the sample inputs at any other time does not alter the frame being sent.
- R11: While `rst_n` is low, `sdo` and `fclk_out` are low and the sampled frame-clock history is low. If no frame edge intervenes, the first bit period after reset release is position 0.
- R12: In follow mode `fclk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock, 256 per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_mode | input | 1 | 1: block generates the frame clock; 0: follows `fclk_in` |
| i2s_align | input | 1 | 0: left-justified framing; 1: I2S-style framing |
| fclk_in | input | 1 | Frame clock from the frame master (follow mode) |
| tdm_in | input | 1 | Cascade data from the upstream device |
| left_smp | input | 24 | Own left sample, two's complement |
| right_smp | input | 24 | Own right sample, two's complement |
| fclk_out | output | 1 | Generated frame clock (lead mode), low otherwise |
| sdo | output | 1 | Serial TDM data |

## Verification
Two functions can fall on the same bit clock.

The first is a follow-mode frame restart while forwarded cascade bits are on the line. The bench provokes it with one-bit and mid-frame frame-clock pulses while pseudo-random data streams into `tdm_in`. It judges every output bit against its own position model and a record of the cascade history.

The second is the frame-start capture of the sample words. The bench changes the sample inputs mid-frame, including to all ones, and checks that the current frame keeps the old words and that the pad bits stay low.

// File: rtl/tdmc_pkg.sv
package tdmc_pkg;
  typedef enum logic {ROLE_FOLLOW = 1'b0, ROLE_LEAD = 1'b1} role_e;
  typedef enum logic {ALIGN_LEFT = 1'b0, ALIGN_I2S = 1'b1} align_e;
endpackage

// File: rtl/tdmc_frame_timer.sv
module tdmc_frame_timer
  import tdmc_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8,
  parameter int POS_W  = $clog2(SLOT_W * SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  role_e            role,
  input  align_e           align,
  input  logic             fclk_in,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] next_pos,
  output logic             resync,
  output logic             fclk_out
);
  localparam int FRAME = SLOT_W * SLOTS;
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME - 1);

  logic fclk_prev;

  function automatic logic [POS_W-1:0] step(input logic [POS_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // Level of the generated frame clock at a given position.
  function automatic logic lead_level(input logic [POS_W-1:0] p, input align_e a);
    if (a == ALIGN_LEFT) return int'(p) < SLOT_W;
    return !((p == LAST) || (int'(p) < SLOT_W - 1));
  endfunction

  logic [POS_W-1:0] start_pos;
  assign start_pos = (align == ALIGN_LEFT) ? '0 : LAST;

  // Start edge: rising for left-justified, falling for I2S.
  assign resync = (role == ROLE_FOLLOW) && (fclk_in != fclk_prev) &&
                  (fclk_in == (align == ALIGN_LEFT));

  assign next_pos = resync ? start_pos : step(pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= LAST;
      fclk_prev <= 1'b0;
      fclk_out  <= 1'b0;
    end else begin
      pos       <= next_pos;
      fclk_prev <= fclk_in;
      fclk_out  <= (role == ROLE_LEAD) ? lead_level(next_pos, align) : 1'b0;
    end
  end
endmodule

// File: rtl/tdmc_fwd_delay.sv
module tdmc_fwd_delay #(
  parameter int DLY = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tap
);
  localparam int STAGES = DLY - 1;

  logic             cap;
  logic [STAGES-1:0] stg;

  // Capture on the edge opposite to the launch edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cap <= 1'b0;
    else        cap <= din;
  end

  generate
    if (STAGES > 1) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], cap};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= cap;
      end
    end
  endgenerate

  assign tap = stg[STAGES-1];
endmodule

// File: rtl/tdmc_slot_mux.sv
module tdmc_slot_mux #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int POS_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [POS_W-1:0]    next_pos,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                fwd_bit,
  output logic                bit_next
);
  localparam int OWN_BITS = 2 * SLOT_W;

  logic [SAMPLE_W-1:0] left_hold, right_hold, left_use;
  logic                frame_load, own_region, right_slot;
  int                  bit_idx;

  function automatic int bit_of(input logic [POS_W-1:0] p);
    return int'(p) % SLOT_W;
  endfunction

  function automatic logic pick(input logic [SAMPLE_W-1:0] w, input int idx);
    logic [SAMPLE_W-1:0] sh;
    if (idx >= SAMPLE_W) return 1'b0;
    sh = w >> (SAMPLE_W - 1 - idx);
    return sh[0];
  endfunction

  assign frame_load = (next_pos == '0);
  assign own_region = int'(next_pos) < OWN_BITS;
  assign right_slot = int'(next_pos) >= SLOT_W;
  assign bit_idx    = bit_of(next_pos);
  assign left_use   = frame_load ? left_in : left_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold  <= '0;
      right_hold <= '0;
    end else if (frame_load) begin
      left_hold  <= left_in;
      right_hold <= right_in;
    end
  end

  always_comb begin
    if (own_region) bit_next = pick(right_slot ? right_hold : left_use, bit_idx);
    else            bit_next = fwd_bit;
  end
endmodule

// File: rtl/tdm_chain_serializer.sv
module tdm_chain_serializer
  import tdmc_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                lead_mode,
  input  logic                i2s_align,
  input  logic                fclk_in,
  input  logic                tdm_in,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  output logic                fclk_out,
  output logic                sdo
);
  localparam int FRAME   = SLOT_W * SLOTS;
  localparam int POS_W   = $clog2(FRAME);
  localparam int FWD_DLY = 2 * SLOT_W;

  role_e            role;
  align_e           align;
  logic [POS_W-1:0] pos, next_pos;
  logic             resync, fwd_tap, bit_next;

  assign role  = role_e'(lead_mode);
  assign align = align_e'(i2s_align);

  tdmc_frame_timer #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .POS_W(POS_W)) i_timer (
    .clk(bclk), .rst_n(rst_n), .role(role), .align(align), .fclk_in(fclk_in),
    .pos(pos), .next_pos(next_pos), .resync(resync), .fclk_out(fclk_out)
  );

  tdmc_fwd_delay #(.DLY(FWD_DLY)) i_fwd (
    .clk(bclk), .rst_n(rst_n), .din(tdm_in), .tap(fwd_tap)
  );

  tdmc_slot_mux #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .POS_W(POS_W)) i_mux (
    .clk(bclk), .rst_n(rst_n), .next_pos(next_pos), .left_in(left_smp),
    .right_in(right_smp), .fwd_bit(fwd_tap), .bit_next(bit_next)
  );

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) sdo <= 1'b0;
    else        sdo <= bit_next;
  end
endmodule

// File: rtl/tdmc_checker.sv
module tdmc_checker #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int POS_W    = 8,
  parameter int FRAME    = 256
) (
  input logic             bclk,
  input logic             rst_n,
  input logic             lead_mode,
  input logic             i2s_align,
  input logic             resync,
  input logic             fwd_tap,
  input logic             fclk_out,
  input logic             sdo,
  input logic [POS_W-1:0] pos
);
  localparam int LAST = FRAME - 1;

  logic pad_pos, fwd_pos;
  assign pad_pos = (int'(pos) < 2 * SLOT_W) && ((int'(pos) % SLOT_W) >= SAMPLE_W);
  assign fwd_pos = int'(pos) >= 2 * SLOT_W;

  a_r1_pos_step: assert property (@(posedge bclk) disable iff (!rst_n)
    (!resync && int'(pos) != LAST) |=> int'(pos) == int'($past(pos)) + 1);

  a_r1_pos_wrap: assert property (@(posedge bclk) disable iff (!rst_n)
    (!resync && int'(pos) == LAST) |=> pos == '0);

  // R8 shares this property through the I2S start value.
  a_r7_resync_start: assert property (@(posedge bclk) disable iff (!rst_n)
    resync |=> int'(pos) == (i2s_align ? LAST : 0));

  a_r3_pad_low: assert property (@(posedge bclk) disable iff (!rst_n)
    pad_pos |-> !sdo);

  a_r4_forward: assert property (@(posedge bclk) disable iff (!rst_n)
    fwd_pos |-> sdo == $past(fwd_tap));

  a_r5_lead_rise: assert property (@(posedge bclk) disable iff (!rst_n)
    (lead_mode && !i2s_align && $rose(fclk_out)) |-> pos == '0);

  a_r6_lead_fall: assert property (@(posedge bclk) disable iff (!rst_n)
    (lead_mode && i2s_align && $fell(fclk_out)) |-> int'(pos) == LAST);

  a_r12_follow_quiet: assert property (@(posedge bclk) disable iff (!rst_n)
    !lead_mode |-> !fclk_out);

  a_r1_lead_free: assert property (@(posedge bclk) disable iff (!rst_n)
    lead_mode |-> !resync);
endmodule

bind tdm_chain_serializer tdmc_checker #(
  .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .POS_W(POS_W), .FRAME(FRAME)
) i_chk (
  .bclk(bclk), .rst_n(rst_n), .lead_mode(lead_mode), .i2s_align(i2s_align),
  .resync(resync), .fwd_tap(fwd_tap), .fclk_out(fclk_out), .sdo(sdo), .pos(pos)
);

// File: tb/test_tdm_chain_serializer.sv
`timescale 1ns/1ps
module test_tdm_chain_serializer;
  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lead_mode = 1'b1, i2s_align = 1'b0;
  logic        fclk_in = 1'b0, tdm_in = 1'b0;
  logic [23:0] left_smp = '0, right_smp = '0;
  logic        fclk_out, sdo;

  always #2 bclk = ~bclk;

  tdm_chain_serializer i_tdm_chain_serializer (
    .bclk(bclk), .rst_n(rst_n), .lead_mode(lead_mode), .i2s_align(i2s_align),
    .fclk_in(fclk_in), .tdm_in(tdm_in), .left_smp(left_smp), .right_smp(right_smp),
    .fclk_out(fclk_out), .sdo(sdo)
  );

  int          checks = 0, errors = 0;
  int          cyc, bpos;
  logic        fprev, m_lead, m_i2s;
  logic        hist [256];
  logic [23:0] lat_l, lat_r;
  logic [15:0] lf = 16'hACE1;
  string       ctx = "";

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d pos %0d: actual %b expected %b",
               req, ctx, cyc, bpos, act, exp);
    end
  endtask

  function automatic logic lfsr_bit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  // Reset with the given mode; R11 checks during reset.
  task automatic start(input logic lead, input logic i2s, input logic fidle);
    rst_n = 1'b0; m_lead = lead; m_i2s = i2s;
    lead_mode = lead; i2s_align = i2s; fclk_in = fidle; tdm_in = 1'b0;
    repeat (3) @(posedge bclk);
    #3;
    check("R11", sdo, 1'b0);
    check("R11", fclk_out, 1'b0);
    rst_n = 1'b1;
    cyc = 0; bpos = 255; fprev = 1'b0; lat_l = '0; lat_r = '0;
  endtask

  // One bit period: model position, drive inputs, check outputs.
  task automatic step(input logic tin, input logic fin);
    logic        exp_s, exp_f;
    logic [23:0] w;
    int          idx;
    string       rq;
    @(posedge bclk);
    cyc++;
    if (!m_lead && fclk_in != fprev && fclk_in == !m_i2s) bpos = m_i2s ? 255 : 0;
    else bpos = (bpos + 1) % 256;
    fprev = fclk_in;
    if (bpos == 0) begin lat_l = left_smp; lat_r = right_smp; end
    #1;
    tdm_in = tin; fclk_in = fin; hist[cyc % 256] = tin;
    #2;
    if (bpos < 64) begin
      w = (bpos < 32) ? lat_l : lat_r;
      idx = bpos % 32;
      exp_s = (idx < 24) ? w[23 - idx] : 1'b0;
      rq = (idx < 24) ? "R2" : "R3";
    end else begin
      exp_s = (cyc > 64) ? hist[(cyc - 64) % 256] : 1'b0;
      rq = "R4";
    end
    check(rq, sdo, exp_s);
    if (!m_lead) begin exp_f = 1'b0; rq = "R12"; end
    else if (m_i2s) begin exp_f = !(bpos == 255 || bpos < 31); rq = "R6"; end
    else begin exp_f = bpos < 32; rq = "R5"; end
    check(rq, fclk_out, exp_f);
  endtask

  task automatic t_lead_left();
    ctx = "R1 R5 R10 R11";
    start(1'b1, 1'b0, 1'b0);
    left_smp = 24'hA5C3F1; right_smp = 24'h5A0F3C;
    for (int k = 0; k < 700; k++) begin
      step(lfsr_bit(), 1'b0);
      if (k == 300) begin left_smp = 24'hFFFFFF; right_smp = 24'h000001; end
      if (k == 540) begin left_smp = 24'h800000; right_smp = 24'hFFFFFF; end
    end
  endtask

  task automatic t_lead_i2s();
    ctx = "R1 R6";
    start(1'b1, 1'b1, 1'b1);
    left_smp = 24'h123456; right_smp = 24'hFEDCBA;
    for (int k = 0; k < 600; k++) step(lfsr_bit(), 1'b1);
  endtask

  task automatic t_follow_left();
    ctx = "R7 R9 R12";
    start(1'b0, 1'b0, 1'b0);
    left_smp = 24'hC0FFEE; right_smp = 24'h0BADF0;
    for (int k = 0; k < 900; k++) begin
      logic f;
      f = (k == 40) || (k >= 296 && k < 328) || (k == 420) || (k == 676);
      if (k == 500) left_smp = 24'h7FFFFF;
      step(lfsr_bit(), f);
    end
  endtask

  task automatic t_follow_i2s();
    ctx = "R8 R9 R12";
    start(1'b0, 1'b1, 1'b1);
    left_smp = 24'h3C3C3C; right_smp = 24'hE1E1E1;
    for (int k = 0; k < 900; k++) begin
      logic f;
      f = !((k == 50) || (k >= 306 && k < 338) || (k == 430) || (k == 686));
      step(lfsr_bit(), f);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_lead_left();
    t_lead_i2s();
    t_follow_left();
    t_follow_i2s();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule